// File: doc/BRIEF.md
# Voice-Band Codec Serial Port

This block is the device side of the four-wire serial link of a voice-band codec. The link carries two kinds of frame. In a primary frame one 16-bit two's-complement ADC sample goes out on DOUT while one 16-bit two's-complement DAC sample comes in on DIN. The frame that follows a completed primary is a secondary frame. In a secondary frame the host sends a control word that either writes a small register file or asks for one register to be shifted back.

A mode pin selects who owns the bit clock and the frame sync. When the pin is high the block divides its system clock into SCLK and generates FS. When the pin is low the host supplies both. Framing and data handling are the same in both cases. SCLK and FS are sampled by the system clock, so in slave mode they must be synchronous to it and each level must last at least one system clock. The ADC side is a valid/ready stream. `adc_ready` pulses for one cycle at the start of each primary frame. A sample is taken only when `adc_valid` is high in that cycle, and a frame with no valid sample sends zeros. The DAC side has no back-pressure, because the port cannot stall: `dac_valid` is a one-cycle strobe and the sink must accept `dac_data` in that cycle.

Top module: `vbc_port`

## Requirements
- R1: With `master_mode`=1, `sclk_oe` and `fs_oe` are high. Each SCLK level lasts SCLK_HALF system clocks. FS is high for one SCLK period around the rising edge that begins a frame. Successive frame starts are 128 SCLK periods apart (a primary every 256, each followed by a secondary 128 later).
- R2: With `master_mode`=0, `sclk_oe` and `fs_oe` are low, and frames follow `sclk_in` and `fs_in` with the same bit timing as R1.
- R3: A frame starts at an SCLK rising edge where FS is high. In a primary frame DOUT carries the ADC word MSB first and changes on rising edges 1 to 16. `dout_oe` is high only from rising edge 1 up to the 17th rising edge. The word is `adc_data` if `adc_valid` is high in the `adc_ready` cycle, otherwise zero.
- R4: DIN is sampled on the 16 SCLK falling edges of a frame, MSB first. After a primary frame, the received word appears on `dac_data` together with a single-cycle `dac_valid` at the 17th rising edge.
- R5: The first frame after reset is primary. The frame after a completed primary is secondary, and the frame after a secondary is primary.
- R6: A secondary word has bits 15:14 = 2'b11 as the request key, bit 13 as the read bit, bits 12:8 as the address and bits 7:0 as the data. When the key matches and the read bit is 0, the data is written to the register at that address at the 17th rising edge.
- R7: When the key matches and the read bit is 1, DOUT sends bits 15:8 as zero and bits 7:0 as the addressed register. No register is written.
- R8: In a secondary frame without a matching read request, all 16 DOUT bits are zero.
- R9: A secondary word whose bits 15:14 are not 2'b11 writes nothing.
- R10: Registers exist at addresses 0 to NREGS-1 (default 8). A write to any other address is dropped, and a read of it returns zero.
- R11: Register 4 holds the gain controls: bits 1:0 are the input gain code (00 = 0 dB, 01 = 6 dB, 10 = 12 dB), bit 2 is input squelch, bits 4:3 are the output gain code (00 = 0 dB, 01 = -6 dB, 10 = -12 dB) and bit 5 is output squelch. These bits drive the gain outputs, and every register resets to zero.
- R12: An FS seen at a rising edge before the 17th edge of the current frame aborts that frame. Nothing is latched or written, and a new primary frame starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| master_mode | input | 1 | 1: block drives SCLK/FS; 0: host drives them |
| sclk_in | input | 1 | bit clock from host (slave mode) |
| fs_in | input | 1 | frame sync from host (slave mode) |
| sclk_out | output | 1 | generated bit clock |
| sclk_oe | output | 1 | enable for the SCLK driver |
| fs_out | output | 1 | generated frame sync |
| fs_oe | output | 1 | enable for the FS driver |
| din | input | 1 | serial data from host |
| dout | output | 1 | serial data to host |
| dout_oe | output | 1 | DOUT driver enable (low = high impedance) |
| adc_valid | input | 1 | ADC sample present |
| adc_ready | output | 1 | one-cycle pulse that takes the ADC sample |
| adc_data | input | 16 | ADC sample, two's complement |
| dac_valid | output | 1 | one-cycle strobe for a new DAC sample |
| dac_data | output | 16 | last DAC sample, two's complement |
| in_gain | output | 2 | input gain code |
| in_mute | output | 1 | input squelch |
| out_gain | output | 2 | output gain code |
| out_mute | output | 1 | output squelch |

## Verification
The assertions assume that SCLK rising edges are at least two system clocks apart. They also assume that `master_mode` changes only while reset is held, so the source of each FS change and each strobe stays fixed. The slave stimulus holds every SCLK level for SCLK_HALF system clocks and changes SCLK, FS and DIN together, away from the sampling edge. The host keeps to the primary/secondary order, except in one deliberate early FS that exercises the abort rule.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int HDR_W    = WORD_W - DATA_W;
  localparam logic [1:0] SEC_KEY = 2'b11;
  // header field positions inside the upper byte of a secondary word
  localparam int KEY_POS  = HDR_W - 2;
  localparam int RD_POS   = ADDR_W;
  // gain register layout
  localparam int IG_LSB   = 0;
  localparam int IM_BIT   = 2;
  localparam int OG_LSB   = 3;
  localparam int OM_BIT   = 5;

  typedef enum logic {FRM_PRI = 1'b0, FRM_SEC = 1'b1} frame_kind_e;
endpackage

// File: rtl/vbc_clk_ctrl.sv
module vbc_clk_ctrl #(
  parameter int SCLK_HALF    = 4,
  parameter int FRAME_PERIOD = 256,
  parameter int SEC_OFFSET   = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic sclk_in,
  input  logic fs_in,
  output logic sclk_gen,
  output logic fs_gen,
  output logic s_rise,
  output logic s_fall,
  output logic fs_lvl
);
  localparam int DIV_W = $clog2(SCLK_HALF + 1);
  localparam int PC_W  = $clog2(FRAME_PERIOD);

  logic [DIV_W-1:0] div_cnt;
  logic [PC_W-1:0]  pcnt;
  logic             sclk_lvl, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sclk_gen <= 1'b0;
      fs_gen   <= 1'b1;
      pcnt     <= PC_W'(FRAME_PERIOD - 1);
    end else if (master) begin
      if (div_cnt == DIV_W'(SCLK_HALF - 1)) begin
        div_cnt  <= '0;
        sclk_gen <= ~sclk_gen;
        if (!sclk_gen)
          pcnt <= (pcnt == PC_W'(FRAME_PERIOD - 1)) ? '0 : pcnt + 1'b1;
        else
          fs_gen <= (pcnt == PC_W'(FRAME_PERIOD - 1)) ||
                    (pcnt == PC_W'(SEC_OFFSET - 1));
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign sclk_lvl = master ? sclk_gen : sclk_in;
  assign fs_lvl   = master ? fs_gen   : fs_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_lvl;
  end

  assign s_rise = sclk_lvl & ~sclk_q;
  assign s_fall = ~sclk_lvl & sclk_q;

  // R1: generated frame sync moves only together with an SCLK falling step
  a_r1_fs_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !$stable(fs_gen)) |-> !sclk_gen);
endmodule

// File: rtl/vbc_regs.sv
module vbc_regs
  import vbc_pkg::*;
#(
  parameter int NREGS     = 8,
  parameter int GAIN_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        in_gain,
  output logic              in_mute,
  output logic [1:0]        out_gain,
  output logic              out_mute
);
  logic [NREGS-1:0][DATA_W-1:0] regs;
  logic [NREGS-1:0][DATA_W-1:0] rd_terms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      for (int i = 0; i < NREGS; i++)
        if (waddr == ADDR_W'(i)) regs[i] <= wdata;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_rd
    assign rd_terms[g] = (raddr == ADDR_W'(g)) ? regs[g] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++) rdata = rdata | rd_terms[i];
  end

  assign in_gain  = regs[GAIN_ADDR][IG_LSB +: 2];
  assign in_mute  = regs[GAIN_ADDR][IM_BIT];
  assign out_gain = regs[GAIN_ADDR][OG_LSB +: 2];
  assign out_mute = regs[GAIN_ADDR][OM_BIT];

  // R10: addresses beyond the file read as zero
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr >= ADDR_W'(NREGS)) |-> (rdata == '0));
endmodule

// File: rtl/vbc_frame_eng.sv
module vbc_frame_eng
  import vbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_rise,
  input  logic              s_fall,
  input  logic              fs_lvl,
  input  logic              din,
  input  logic              adc_valid,
  input  logic [WORD_W-1:0] adc_data,
  output logic              adc_ready,
  output logic              dout,
  output logic              dout_oe,
  output logic [WORD_W-1:0] dac_data,
  output logic              dac_valid,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_raddr,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic              busy, exp_sec, rd_active;
  frame_kind_e       kind, nk;
  logic [CNT_W-1:0]  rcnt, icnt;
  logic [WORD_W-1:0] sh_out, sh_in, tx_word;
  logic              last_edge, start, abort, rd_ok;
  logic [DATA_W-1:0] rd_byte;

  assign last_edge = busy && (rcnt == CNT_W'(WORD_W));
  assign start     = s_rise && fs_lvl;
  assign abort     = start && busy && !last_edge;

  always_comb begin
    if (abort)          nk = FRM_PRI;
    else if (last_edge) nk = (kind == FRM_PRI) ? FRM_SEC : FRM_PRI;
    else                nk = exp_sec ? FRM_SEC : FRM_PRI;
  end

  assign adc_ready = start && (nk == FRM_PRI);
  assign tx_word   = (adc_ready && adc_valid) ? adc_data : '0;

  // header = upper byte of the secondary word, complete after 8 falls
  assign reg_raddr = sh_in[ADDR_W-1:0];
  assign rd_ok     = busy && (sh_in[KEY_POS +: 2] == SEC_KEY) && sh_in[RD_POS];
  assign rd_byte   = rd_ok ? reg_rdata : '0;

  assign reg_we    = s_rise && last_edge && (kind == FRM_SEC) &&
                     (sh_in[WORD_W-1 -: 2] == SEC_KEY) && !sh_in[DATA_W + RD_POS];
  assign reg_waddr = sh_in[DATA_W +: ADDR_W];
  assign reg_wdata = sh_in[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kind      <= FRM_PRI;
      exp_sec   <= 1'b0;
      rcnt      <= '0;
      icnt      <= '0;
      sh_out    <= '0;
      sh_in     <= '0;
      rd_active <= 1'b0;
      dout      <= 1'b0;
      dout_oe   <= 1'b0;
      dac_data  <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      if (s_rise) begin
        if (last_edge) begin
          busy      <= 1'b0;
          dout_oe   <= 1'b0;
          dout      <= 1'b0;
          rd_active <= 1'b0;
          if (kind == FRM_PRI) begin
            dac_data  <= sh_in;
            dac_valid <= 1'b1;
            exp_sec   <= 1'b1;
          end else begin
            exp_sec <= 1'b0;
          end
        end else if (busy) begin
          rcnt <= rcnt + 1'b1;
          if (kind == FRM_SEC && rcnt == CNT_W'(HDR_W)) begin
            rd_active <= rd_ok;
            dout      <= rd_byte[DATA_W-1];
            sh_out    <= {rd_byte[DATA_W-2:0], {(HDR_W+1){1'b0}}};
          end else begin
            dout   <= sh_out[WORD_W-1];
            sh_out <= {sh_out[WORD_W-2:0], 1'b0};
          end
        end
        if (start) begin
          busy      <= 1'b1;
          kind      <= nk;
          rcnt      <= CNT_W'(1);
          icnt      <= '0;
          dout_oe   <= 1'b1;
          rd_active <= 1'b0;
          dout      <= tx_word[WORD_W-1];
          sh_out    <= {tx_word[WORD_W-2:0], 1'b0};
          if (abort || nk == FRM_SEC) exp_sec <= 1'b0;
        end
      end
      if (s_fall && busy && icnt < CNT_W'(WORD_W)) begin
        sh_in <= {sh_in[WORD_W-2:0], din};
        icnt  <= icnt + 1'b1;
      end
    end
  end

  // R4: the DAC strobe is a single cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);
  // R12: an aborted frame never produces a DAC strobe
  a_r12_abort_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !dac_valid);
  // R3: a taken ADC handshake opens the DOUT window of a primary frame
  a_r3_ready_opens: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ready |=> (dout_oe && kind == FRM_PRI));
  // R8: secondary frames without a read keep DOUT low
  a_r8_sec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && kind == FRM_SEC && !rd_active) |-> !dout);
  // R6: register writes happen only at the close of a secondary frame
  a_r6_write_in_sec: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (busy && kind == FRM_SEC && s_rise));
endmodule

// File: rtl/vbc_port.sv
module vbc_port
  import vbc_pkg::*;
#(
  parameter int SCLK_HALF    = 4,
  parameter int FRAME_PERIOD = 256,
  parameter int SEC_OFFSET   = 128,
  parameter int NREGS        = 8,
  parameter int GAIN_ADDR    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master_mode,
  input  logic        sclk_in,
  input  logic        fs_in,
  output logic        sclk_out,
  output logic        sclk_oe,
  output logic        fs_out,
  output logic        fs_oe,
  input  logic        din,
  output logic        dout,
  output logic        dout_oe,
  input  logic        adc_valid,
  output logic        adc_ready,
  input  logic [15:0] adc_data,
  output logic        dac_valid,
  output logic [15:0] dac_data,
  output logic [1:0]  in_gain,
  output logic        in_mute,
  output logic [1:0]  out_gain,
  output logic        out_mute
);
  logic              s_rise, s_fall, fs_lvl;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_waddr, reg_raddr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;

  assign sclk_oe = master_mode;
  assign fs_oe   = master_mode;

  vbc_clk_ctrl #(
    .SCLK_HALF(SCLK_HALF), .FRAME_PERIOD(FRAME_PERIOD), .SEC_OFFSET(SEC_OFFSET)
  ) u_clk (
    .clk(clk), .rst_n(rst_n), .master(master_mode),
    .sclk_in(sclk_in), .fs_in(fs_in),
    .sclk_gen(sclk_out), .fs_gen(fs_out),
    .s_rise(s_rise), .s_fall(s_fall), .fs_lvl(fs_lvl)
  );

  vbc_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n),
    .s_rise(s_rise), .s_fall(s_fall), .fs_lvl(fs_lvl), .din(din),
    .adc_valid(adc_valid), .adc_data(adc_data), .adc_ready(adc_ready),
    .dout(dout), .dout_oe(dout_oe),
    .dac_data(dac_data), .dac_valid(dac_valid),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  vbc_regs #(.NREGS(NREGS), .GAIN_ADDR(GAIN_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata),
    .in_gain(in_gain), .in_mute(in_mute),
    .out_gain(out_gain), .out_mute(out_mute)
  );
endmodule

// File: tb/vbc_port_tb_top.sv
module vbc_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, master_mode = 1'b0;
  logic sclk_in = 1'b0, fs_in = 1'b0, din = 1'b0, adc_valid = 1'b0;
  logic [15:0] adc_data = '0;
  logic sclk_out, sclk_oe, fs_out, fs_oe, dout, dout_oe, adc_ready, dac_valid;
  logic [15:0] dac_data;
  logic [1:0] in_gain, out_gain;
  logic in_mute, out_mute;

  int checks = 0, errors = 0;
  logic [15:0] dac_q[$];
  logic [15:0] rx;
  int gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbc_port #(.SCLK_HALF(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .sclk_in(sclk_in), .fs_in(fs_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .fs_out(fs_out), .fs_oe(fs_oe), .din(din), .dout(dout), .dout_oe(dout_oe),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_data(adc_data),
    .dac_valid(dac_valid), .dac_data(dac_data),
    .in_gain(in_gain), .in_mute(in_mute), .out_gain(out_gain), .out_mute(out_mute)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for DAC samples (R4)
  always @(negedge clk) begin
    if (rst_n && dac_valid) begin
      if (dac_q.size() == 0) chk(1'b0, "R4 R12 unexpected dac strobe", {16'h0, dac_data}, 32'h0);
      else begin
        logic [15:0] e;
        e = dac_q.pop_front();
        chk(dac_data == e, "R4 dac word", {16'h0, dac_data}, {16'h0, e});
      end
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input bit rd, input logic [4:0] a, input logic [7:0] d);
    return {2'b11, rd, a, d};
  endfunction

  task automatic s_frame(input logic [15:0] tx, input int nrise, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < nrise; i++) begin
      sclk_in = 1'b1; fs_in = (i == 0); din = (i < 16) ? tx[15-i] : 1'b0;
      hw();
      if (i < 16) r[15-i] = dout;
      sclk_in = 1'b0; fs_in = 1'b0;
      hw();
    end
  endtask

  task automatic s_pri(input logic [15:0] a, input bit v, input logic [15:0] d);
    adc_data = a; adc_valid = v;
    dac_q.push_back(d);
    s_frame(d, 17, rx);
    chk(rx == (v ? a : 16'h0), "R3 adc word on dout", {16'h0, rx}, {16'h0, v ? a : 16'h0});
    chk(dout_oe == 1'b0, "R3 dout released", {31'h0, dout_oe}, 32'h0);
    adc_valid = 1'b0;
  endtask

  task automatic wait_lvl(input bit l);
    do @(negedge clk); while (sclk_out !== l);
  endtask

  task automatic m_frame(input logic [15:0] tx, output logic [15:0] r, output int g);
    g = 0; r = '0;
    do begin wait_lvl(1'b0); wait_lvl(1'b1); g++; end while (fs_out !== 1'b1);
    for (int i = 0; i < 17; i++) begin
      din = (i < 16) ? tx[15-i] : 1'b0;
      if (i < 16) begin
        wait_lvl(1'b0);
        r[15-i] = dout;
        wait_lvl(1'b1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // ---------------- slave mode ----------------
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R3 reset dout_oe", {31'h0, dout_oe}, 32'h0);
    chk(sclk_oe == 1'b0 && fs_oe == 1'b0, "R2 slave enables low", {30'h0, sclk_oe, fs_oe}, 32'h0);
    chk({in_gain, in_mute, out_gain, out_mute} == 6'h0, "R11 reset gains",
        {26'h0, in_gain, in_mute, out_gain, out_mute}, 32'h0);

    s_pri(16'h8123, 1'b1, 16'h5A5A);                        // R5 first frame primary
    s_frame(ctl(1'b0, 5'd4, 8'h2E), 17, rx);                 // R6 write gains
    chk(rx == 16'h0, "R8 secondary no read zero", {16'h0, rx}, 32'h0);
    chk(in_gain == 2'b10 && in_mute && out_gain == 2'b01 && out_mute, "R11 gain fields",
        {26'h0, in_gain, in_mute, out_gain, out_mute}, {26'h0, 6'b101011});

    s_pri(16'h1234, 1'b0, 16'h0001);                        // R3 no valid sample
    s_frame(ctl(1'b1, 5'd4, 8'hFF), 17, rx);
    chk(rx == 16'h002E, "R7 read back gain reg", {16'h0, rx}, 32'h002E);
    chk(in_gain == 2'b10 && out_gain == 2'b01, "R7 read writes nothing",
        {28'h0, in_gain, out_gain}, {28'h0, 4'b1001});

    s_pri(16'h7FFF, 1'b1, 16'hFFFF);
    s_frame({2'b01, 1'b0, 5'd4, 8'h00}, 17, rx);            // R9 bad key
    chk(rx == 16'h0, "R9 bad key dout zero", {16'h0, rx}, 32'h0);
    chk(in_gain == 2'b10 && in_mute, "R9 bad key ignored", {29'h0, in_gain, in_mute}, {29'h0, 3'b101});

    s_pri(16'h0F0F, 1'b1, 16'h8000);
    s_frame(ctl(1'b0, 5'd20, 8'h77), 17, rx);               // R10
    s_pri(16'hF0F0, 1'b1, 16'h1357);
    s_frame(ctl(1'b1, 5'd20, 8'h00), 17, rx);
    chk(rx == 16'h0, "R10 unused address reads zero", {16'h0, rx}, 32'h0);

    s_pri(16'hAAAA, 1'b1, 16'h2468);
    s_frame(ctl(1'b0, 5'd2, 8'hC3), 17, rx);                // R6
    s_pri(16'h5555, 1'b1, 16'hACE1);
    s_frame(ctl(1'b1, 5'd2, 8'h00), 17, rx);
    chk(rx == 16'h00C3, "R6 write then read reg2", {16'h0, rx}, 32'h00C3);

    // R12: early FS aborts a primary frame
    adc_data = 16'h1111; adc_valid = 1'b1;
    s_frame(16'hFFFF, 9, rx);
    s_pri(16'h7FFE, 1'b1, 16'h4321);
    chk(rx == 16'h7FFE, "R12 restart as primary", {16'h0, rx}, 32'h7FFE);
    s_frame(ctl(1'b1, 5'd2, 8'h00), 17, rx);
    chk(rx == 16'h00C3, "R5 secondary follows restarted primary", {16'h0, rx}, 32'h00C3);
    hw();
    chk(dac_q.size() == 0, "R4 all dac words seen", dac_q.size(), 32'h0);

    // ---------------- master mode ----------------
    rst_n = 1'b0; master_mode = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(sclk_oe && fs_oe, "R1 master enables high", {30'h0, sclk_oe, fs_oe}, 32'h3);
    adc_data = 16'hBEEF; adc_valid = 1'b1;
    dac_q.push_back(16'hC0DE);
    m_frame(16'hC0DE, rx, gap);
    chk(rx == 16'hBEEF, "R3 master primary dout", {16'h0, rx}, 32'hBEEF);
    adc_valid = 1'b0;
    m_frame(ctl(1'b0, 5'd3, 8'h96), rx, gap);
    chk(gap == 112, "R1 secondary spacing", gap, 32'd112);
    chk(rx == 16'h0, "R8 master secondary zero", {16'h0, rx}, 32'h0);
    adc_data = 16'h0042; adc_valid = 1'b1;
    dac_q.push_back(16'h0F00);
    m_frame(16'h0F00, rx, gap);
    chk(gap == 112 && rx == 16'h0042, "R5 master primary after secondary", {16'h0, rx}, 32'h0042);
    adc_valid = 1'b0;
    m_frame(ctl(1'b1, 5'd3, 8'h00), rx, gap);
    chk(rx == 16'h0096, "R7 master read back", {16'h0, rx}, 32'h0096);
    begin
      int n;
      wait_lvl(1'b0); wait_lvl(1'b1);
      n = 0;
      do begin @(negedge clk); n++; end while (sclk_out == 1'b1);
      chk(n == H, "R1 sclk half period", n, H);
    end
    chk(dac_q.size() == 0, "R4 master dac words seen", dac_q.size(), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule